// File: doc/BRIEF.md
# Switchable Nonvolatile Byte Window Controller

This block sits between the external-data bus of an 8-bit controller and a small on-chip nonvolatile byte array. It decodes each bus read or write strobe. Each access goes either to the ordinary RAM port or to the array. The array takes the place of the lowest `NVM_BYTES` addresses of the external data space only while software has set an enable bit in a control/status register. Above that window, and in the window while the bit is clear, every access passes to RAM unchanged.

A write that lands in the enabled window starts a byte programming cycle. The address and data are captured, and a busy flag in the control/status register goes high. The byte is stored in the array in the last cycle of a fixed programming time of `PROG_CYCLES` clocks, and the flag then clears. While the flag is high, the window is locked:

- Reads to the window return 0xFF.
- Writes to the window are dropped.
- Neither reaches RAM.

The programming sequencer is a three-state machine:

- **ST_IDLE**: not busy. An accepted window write takes the transition *start* into ST_PROGRAM.
- **ST_PROGRAM**: counts down `PROG_CYCLES-1` cycles. The transition *count_done* leads to ST_COMMIT.
- **ST_COMMIT**: writes the captured byte into the array. The transition *finish* returns to ST_IDLE.
- Reset takes the transition *abort* from any state to ST_IDLE, without storing anything.

Top module: `nvm_window_ctrl`

## Requirements
- R1: With the enable bit set, a bus read or write whose address is below `NVM_BYTES` (0x0800 by default) goes to the array and raises neither `ram_rd` nor `ram_wr`.
- R2: An access whose address is `NVM_BYTES` or above always goes to RAM: `ram_wr`/`ram_rd` follow the strobe in the same cycle, with `ram_addr` and `ram_wdata` equal to the bus values, whatever the enable bit is.
- R3: With the enable bit clear, accesses below `NVM_BYTES` also go to RAM exactly as in R2.
- R4: An accepted window write sets the busy flag (`csr_rdata` bit 1) from the cycle after the strobe, for exactly `PROG_CYCLES` cycles.
- R5: After the busy flag clears, a window read returns the byte last written there, including at the top address of the window.
- R6: A window write issued while busy is dropped: no RAM strobe, no change to the stored byte, and the busy period is not extended.
- R7: A window read issued while busy returns 0xFF and raises no `ram_rd`.
- R8: The status register reads {6'b0, busy, enable} (enable in bit 0, busy in bit 1). A `csr_wr` loads only bit 0 of `csr_wdata` into enable, in the next cycle. Busy cannot be written by software.
- R9: Reset clears the enable bit, the busy flag and `bus_rdata`. It also aborts a programming cycle in progress, so the array keeps its previous byte.
- R10: Read data on `bus_rdata` is registered and is valid in the cycle after the read strobe, for RAM and array reads alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | External-data bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Bus write strobe, one cycle |
| bus_rd | input | 1 | Bus read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Control/status write data (bit 0 = enable) |
| csr_rdata | output | 8 | Control/status read value {0, busy, enable} |
| ram_addr | output | 16 | RAM port address |
| ram_wdata | output | 8 | RAM port write data |
| ram_wr | output | 1 | RAM write strobe |
| ram_rd | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data, combinational from the RAM |

## Verification
The timing of each result is fixed:

- RAM strobes are combinational. The bench samples them one nanosecond after it drives a bus strobe.
- Read data lands one edge after the read strobe. The monitor sees the strobe at the rising edge, then pops its queued expected byte and compares it at the following falling edge.
- The busy flag is first seen at the falling edge after the accepted write. It must hold at every one of the next `PROG_CYCLES` falling edges and be low at the one after.
- The bench counts these falling edges from the first write, so a dropped second write that restarted the counter would show up as a longer busy run.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PROGRAM = 2'd1,
        ST_COMMIT  = 2'd2
    } prog_state_t;

    localparam int CSR_EN_BIT   = 0;
    localparam int CSR_BUSY_BIT = 1;
endpackage

// File: rtl/nvw_decode.sv
module nvw_decode #(
    parameter int ADDR_W    = 16,
    parameter int NVM_BYTES = 2048
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              enable,
    input  logic              busy,
    output logic              win_hit,
    output logic              nvm_start,
    output logic              ram_rd,
    output logic              ram_wr
);
    localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(NVM_BYTES);

    logic in_range;

    always_comb begin
        in_range  = ({1'b0, bus_addr} < WIN_END);
        win_hit   = enable && in_range;
        nvm_start = win_hit && bus_wr && !busy;
        ram_rd    = bus_rd && !win_hit;
        ram_wr    = bus_wr && !win_hit;
    end
endmodule

// File: rtl/nvw_prog_fsm.sv
module nvw_prog_fsm
    import nvw_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    output logic          busy,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    localparam int              CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 2);

    prog_state_t      state;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_PROGRAM;
                        cnt    <= LOAD;
                        addr_q <= start_addr;
                        data_q <= start_data;
                    end
                end
                ST_PROGRAM: begin
                    if (cnt == '0) state <= ST_COMMIT;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_COMMIT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        busy        = (state != ST_IDLE);
        commit      = (state == ST_COMMIT);
        commit_addr = addr_q;
        commit_data = data_q;
    end
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DW-1:0]            rd_data
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvm_window_ctrl.sv
module nvm_window_ctrl
    import nvw_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int NVM_BYTES   = 2048,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_wr,
    output logic              ram_rd,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int NVM_AW = $clog2(NVM_BYTES);

    logic              enable;
    logic              busy;
    logic              win_hit;
    logic              nvm_start;
    logic              commit;
    logic [NVM_AW-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] arr_q;

    nvw_decode #(.ADDR_W(ADDR_W), .NVM_BYTES(NVM_BYTES)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .enable   (enable),
        .busy     (busy),
        .win_hit  (win_hit),
        .nvm_start(nvm_start),
        .ram_rd   (ram_rd),
        .ram_wr   (ram_wr)
    );

    nvw_prog_fsm #(.AW(NVM_AW), .DW(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (nvm_start),
        .start_addr (bus_addr[NVM_AW-1:0]),
        .start_data (bus_wdata),
        .busy       (busy),
        .commit     (commit),
        .commit_addr(commit_addr),
        .commit_data(commit_data)
    );

    nvw_array #(.DEPTH(NVM_BYTES), .DW(DATA_W)) u_arr (
        .clk    (clk),
        .wr_en  (commit),
        .wr_addr(commit_addr),
        .wr_data(commit_data),
        .rd_addr(bus_addr[NVM_AW-1:0]),
        .rd_data(arr_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      enable <= 1'b0;
        else if (csr_wr) enable <= csr_wdata[CSR_EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (!win_hit)  bus_rdata <= ram_rdata;
            else if (busy) bus_rdata <= '1;
            else           bus_rdata <= arr_q;
        end
    end

    always_comb begin
        csr_rdata               = '0;
        csr_rdata[CSR_EN_BIT]   = enable;
        csr_rdata[CSR_BUSY_BIT] = busy;
        ram_addr                = bus_addr;
        ram_wdata               = bus_wdata;
    end
endmodule

// File: rtl/nvw_checker.sv
module nvw_checker #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int NVM_BYTES   = 2048,
    parameter int PROG_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              csr_wr,
    input logic [DATA_W-1:0] csr_wdata,
    input logic [DATA_W-1:0] csr_rdata,
    input logic              ram_wr,
    input logic              ram_rd
);
    logic low_addr;
    logic en_s;
    logic busy_s;
    int   busy_run;

    assign low_addr = ({1'b0, bus_addr} < (ADDR_W+1)'(NVM_BYTES));
    assign en_s     = csr_rdata[0];
    assign busy_s   = csr_rdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run <= 0;
        else if (busy_s) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    // R1
    window_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && low_addr) |-> (!ram_wr && !ram_rd));

    // R2
    high_goes_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_addr && bus_wr) |-> ram_wr);

    // R4
    busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && en_s && low_addr && !busy_s) |=> busy_s);

    // R4
    busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_s |-> (busy_run < PROG_CYCLES));

    // R7
    busy_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && en_s && low_addr && busy_s) |=> (bus_rdata == '1));

    // R8
    csr_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[DATA_W-1:2] == '0);

    // R8
    enable_follows_csr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (en_s == $past(csr_wdata[0])));
endmodule

bind nvm_window_ctrl nvw_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NVM_BYTES(NVM_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_nvw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .csr_wr   (csr_wr),
    .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata),
    .ram_wr   (ram_wr),
    .ram_rd   (ram_rd)
);

// File: tb/nvm_window_ctrl_bench.sv
module nvm_window_ctrl_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        csr_wr = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_wr;
    logic        ram_rd;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int failures = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] ram_model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign ram_rdata = ram_model(ram_addr);

    nvm_window_ctrl #(.PROG_CYCLES(N)) u_nvm_window_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_wr(ram_wr),
        .ram_rd(ram_rd), .ram_rdata(ram_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: read strobe seen at an edge, data compared at next falling edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd && rst_n) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "monitor: unexpected read", bus_rdata, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(bus_rdata == e, t, bus_rdata, e);
                end
            end
        end
    end

    task automatic csr_write(input logic [7:0] v);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input bit exp_ram, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        check(ram_wr == exp_ram, tag, ram_wr, exp_ram);
        if (exp_ram) check(ram_addr == a && ram_wdata == d, tag, {ram_addr, ram_wdata}, {a, d});
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [7:0] e,
                            input bit exp_ram, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        #1;
        check(ram_rd == exp_ram, tag, ram_rd, exp_ram);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // called at the falling edge right after the write edge
    task automatic busy_run(input string tag);
        int bad = 0;
        for (int k = 1; k <= N; k++) begin
            if (!csr_rdata[1]) bad++;
            @(negedge clk);
        end
        check(bad == 0, tag, bad, 0);
        check(csr_rdata[1] == 1'b0, tag, csr_rdata[1], 0);
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(csr_rdata == 8'h00, "R9 reset csr", csr_rdata, 0);
        check(bus_rdata == 8'h00, "R9 reset rdata", bus_rdata, 0);
        rst_n = 1'b1;

        // R3: window routed to RAM while disabled; R10 read latency
        bus_write(16'h0123, 8'hA7, 1'b1, "R3 low write to RAM");
        bus_read(16'h0123, ram_model(16'h0123), 1'b1, "R3 R10 low read from RAM");

        // R8: only the enable bit is writable
        csr_write(8'hFF);
        check(csr_rdata == 8'h01, "R8 csr write only enable", csr_rdata, 8'h01);

        // R2: high addresses always RAM
        bus_write(16'h0800, 8'h44, 1'b1, "R2 write at window end");
        bus_read(16'h0ABC, ram_model(16'h0ABC), 1'b1, "R2 R10 high read");

        // R1 R4: window write starts programming
        bus_write(16'h0010, 8'h5A, 1'b0, "R1 window write no RAM");
        busy_run("R4 busy run");
        bus_read(16'h0010, 8'h5A, 1'b0, "R5 readback");
        bus_write(16'h07FF, 8'hC3, 1'b0, "R1 top of window write");
        busy_run("R4 busy run top");
        bus_read(16'h07FF, 8'hC3, 1'b0, "R5 readback top");

        // R6 R7: accesses while busy
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h0020; bus_wdata = 8'h11;      // n0
        @(negedge clk);                                              // n1
        bus_wr = 1'b0; bus_rd = 1'b1;
        exp_q.push_back(8'hFF); tag_q.push_back("R7 busy read 0xFF");
        #1;
        check(ram_rd == 1'b0, "R7 busy read no RAM", ram_rd, 0);
        @(negedge clk);                                              // n2
        bus_rd = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h22;
        #1;
        check(ram_wr == 1'b0, "R6 dropped write no RAM", ram_wr, 0);
        @(negedge clk);                                              // n3
        bus_wr = 1'b0;
        repeat (N - 3) @(negedge clk);                               // nN
        check(csr_rdata[1] == 1'b1, "R6 busy through N", csr_rdata[1], 1);
        @(negedge clk);
        check(csr_rdata[1] == 1'b0, "R6 busy not extended", csr_rdata[1], 0);
        bus_read(16'h0020, 8'h11, 1'b0, "R6 dropped write kept old byte");

        // R3: disabling restores RAM view
        csr_write(8'h00);
        bus_read(16'h0010, ram_model(16'h0010), 1'b1, "R3 disabled read");
        csr_write(8'h01);

        // R9: reset aborts programming
        bus_write(16'h0010, 8'h99, 1'b0, "R1 write before reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(csr_rdata == 8'h00, "R9 reset clears busy and enable", csr_rdata, 0);
        rst_n = 1'b1;
        csr_write(8'h01);
        bus_read(16'h0010, 8'h5A, 1'b0, "R9 aborted write not stored");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "monitor queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule